// File: doc/BRIEF.md
# CAM Entry Learning and Aging Controller

This block owns a small associative table and the four status flags that every entry carries: free, excluded, pinned and referenced. A lookup compares a presented key against all live entries at once and reports the lowest-index matching slot one cycle later. Any slot that a lookup finds is marked as referenced. After a lookup that misses, a learn command stores the key that was looked up into the lowest free slot. This gives a Layer 2 bridge its address learning without software copying keys into place.

A periodic aging pulse from an external timer sweeps the table. Every live entry that has not been referenced since the previous pulse, and is not pinned, is released. Then all referenced flags are cleared for the next interval. Software can pin or unpin a slot and can exclude a slot from lookups, which also covers slots it has reserved but not yet filled. When one key sits in several slots, a step command excludes the slot just reported and looks up again, so the matches come out one at a time in index order. These step exclusions are dropped as soon as a new key is looked up.

Top module: `cam_learn_age`

## Requirements
- R1: After reset every slot is free, unpinned, unexcluded and unreferenced, `rsp_valid` and `rsp_hit` are 0, and a lookup of any key misses.
- R2: A lookup (`srch_valid`) makes `rsp_valid` high for exactly the next cycle. `rsp_hit`/`rsp_idx` then give the lowest-index slot that is live, not excluded and holds the key, or `rsp_hit`=0 if there is none. Free slots never match.
- R3: A slot reported as a hit by a lookup or a step has its referenced flag set, so it survives the next aging pulse.
- R4: A learn (`learn_valid`) takes effect only when the most recent lookup result is a miss. It writes the looked-up key into the lowest-index free slot and marks that slot live, referenced, unpinned and unexcluded. The following cycle shows `rsp_hit`=1 and `rsp_idx`= that slot. A learn with no key looked up since reset, or after a hit, changes nothing.
- R5: A learn when no slot is free changes nothing; every stored key stays in its slot.
- R6: On an aging pulse, each live slot whose referenced flag is clear and whose pinned flag is clear becomes free. All referenced flags are then 0. An entry that is neither looked up nor learned is therefore released by the second pulse after it was last referenced.
- R7: A pinned slot is never released by aging.
- R8: `mark_valid` writes `mark_val` into the flag of slot `mark_idx` chosen by `mark_field`: 0 selects pinned, 1 selects excluded. An excluded slot never matches until the flag is written back to 0.
- R9: A step (`next_valid`) excludes the currently reported hit slot and looks up the held key again, pulsing `rsp_valid` as in R2. A new lookup cancels all step exclusions but leaves the exclusions written through `mark_valid` in place.
- R10: When several commands arrive in one cycle, only one is carried out, in the order lookup, step, learn, mark, aging; the rest are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| srch_valid | input | 1 | Look up `srch_key` and hold it as the current key |
| srch_key | input | KEY_W | Key to look up |
| next_valid | input | 1 | Step to the next match of the held key |
| learn_valid | input | 1 | Store the held key after a miss |
| mark_valid | input | 1 | Write a pinned or excluded flag |
| mark_idx | input | IW | Slot addressed by the flag write |
| mark_field | input | 1 | 0 = pinned flag, 1 = excluded flag |
| mark_val | input | 1 | Value written to the flag |
| age_tick | input | 1 | One-cycle aging pulse from the timer |
| rsp_valid | output | 1 | Lookup or step result present this cycle |
| rsp_hit | output | 1 | Last result matched a slot |
| rsp_idx | output | IW | Slot of the last hit |

## Verification
The bench builds the block with ENTRIES=4 and KEY_W=8. With four slots, the table fills after four learns, so the refused learn into a full table is reached in a few cycles. It also lets one key be placed in two slots, using an exclusion to force the second learn, so step walking reaches both matches and then the final miss. The small table also makes the two-pulse release of unreferenced entries, and its interaction with pinning, easy to observe from lookups alone.

// File: rtl/cam_pkg.sv
// Shared command encoding for the learning and aging controller.
// Assumes at most one command is carried out per cycle.
package cam_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_LOOKUP,
        CMD_STEP,
        CMD_LEARN,
        CMD_MARK,
        CMD_AGE
    } cam_cmd_e;

    localparam logic FLAG_PIN  = 1'b0;
    localparam logic FLAG_EXCL = 1'b1;

endpackage

// File: rtl/cam_prio_enc.sv
// Lowest-index-first priority encoder.
// Assumes IW is wide enough to hold N-1.
module cam_prio_enc #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/cam_match_array.sv
// Parallel equality compare of one key against every stored key.
// Assumes the caller masks out slots that must not take part.
module cam_match_array #(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 16
) (
    input  logic [ENTRIES*KEY_W-1:0] keys_flat,
    input  logic [KEY_W-1:0]         key,
    input  logic [ENTRIES-1:0]       eligible,
    output logic [ENTRIES-1:0]       match
);

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            // One comparator per slot, gated by eligibility.
            assign match[g] = eligible[g] &&
                              (keys_flat[g*KEY_W +: KEY_W] == key);
        end
    endgenerate

endmodule

// File: rtl/cam_entry_store.sv
// Key storage and per-slot flags: free, excluded (software and step), pinned, referenced.
// Assumes the update strobes are mutually exclusive within a cycle.
module cam_entry_store #(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 16,
    parameter int IW      = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_clr,
    input  logic                     step_set,
    input  logic [IW-1:0]            step_idx,
    input  logic                     touch_en,
    input  logic [IW-1:0]            touch_idx,
    input  logic                     learn_en,
    input  logic [IW-1:0]            learn_idx,
    input  logic [KEY_W-1:0]         learn_key,
    input  logic                     mark_en,
    input  logic [IW-1:0]            mark_idx,
    input  logic                     mark_field,
    input  logic                     mark_val,
    input  logic                     sweep_en,
    output logic [ENTRIES*KEY_W-1:0] keys_flat,
    output logic [ENTRIES-1:0]       free_v,
    output logic [ENTRIES-1:0]       excl_v,
    output logic [ENTRIES-1:0]       step_v,
    output logic [ENTRIES-1:0]       pin_v,
    output logic [ENTRIES-1:0]       ref_v
);
    import cam_pkg::*;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_slot
            logic [KEY_W-1:0] key_q;
            logic             free_q, excl_q, step_q, pin_q, ref_q;
            logic             hit_learn, hit_mark, hit_step, hit_touch;

            // Decode which strobes address this slot.
            assign hit_learn = learn_en && (learn_idx == IW'(g));
            assign hit_mark  = mark_en  && (mark_idx  == IW'(g));
            assign hit_step  = step_set && (step_idx  == IW'(g));
            assign hit_touch = touch_en && (touch_idx == IW'(g));

            // Slot state update.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    key_q  <= '0;
                    free_q <= 1'b1;
                    excl_q <= 1'b0;
                    step_q <= 1'b0;
                    pin_q  <= 1'b0;
                    ref_q  <= 1'b0;
                end else begin
                    if (step_clr) begin
                        step_q <= 1'b0;
                    end
                    if (hit_step) begin
                        step_q <= 1'b1;
                    end
                    if (hit_touch) begin
                        ref_q <= 1'b1;
                    end
                    if (hit_learn) begin
                        key_q  <= learn_key;
                        free_q <= 1'b0;
                        ref_q  <= 1'b1;
                        pin_q  <= 1'b0;
                        excl_q <= 1'b0;
                        step_q <= 1'b0;
                    end
                    if (hit_mark) begin
                        if (mark_field == FLAG_PIN) begin
                            pin_q <= mark_val;
                        end else begin
                            excl_q <= mark_val;
                        end
                    end
                    if (sweep_en) begin
                        if (!free_q && !ref_q && !pin_q) begin
                            free_q <= 1'b1;
                        end
                        ref_q <= 1'b0;
                    end
                end
            end

            assign keys_flat[g*KEY_W +: KEY_W] = key_q;
            assign free_v[g] = free_q;
            assign excl_v[g] = excl_q;
            assign step_v[g] = step_q;
            assign pin_v[g]  = pin_q;
            assign ref_v[g]  = ref_q;
        end
    endgenerate

endmodule

// File: rtl/cam_learn_age.sv
// Top: command arbitration, lookup/step, learning into free slots, aging sweep.
// Assumes one command carried out per cycle; lower-priority commands are dropped.
module cam_learn_age #(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 16,
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srch_valid,
    input  logic [KEY_W-1:0] srch_key,
    input  logic             next_valid,
    input  logic             learn_valid,
    input  logic             mark_valid,
    input  logic [IW-1:0]    mark_idx,
    input  logic             mark_field,
    input  logic             mark_val,
    input  logic             age_tick,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [IW-1:0]    rsp_idx
);
    import cam_pkg::*;

    cam_cmd_e                 cmd;
    logic [KEY_W-1:0]         cur_key_q;
    logic                     key_ok_q;
    logic                     rsp_valid_q, rsp_hit_q;
    logic [IW-1:0]            rsp_idx_q;
    logic [ENTRIES*KEY_W-1:0] keys_flat;
    logic [ENTRIES-1:0]       empty_v, excl_v, step_v, perm_v, age_v;
    logic [ENTRIES-1:0]       cur_oh, eligible, match_v;
    logic [KEY_W-1:0]         cmp_key;
    logic                     m_found, f_found, do_learn;
    logic [IW-1:0]            m_idx, f_idx;

    // Fixed-priority command selection.
    always_comb begin
        if (srch_valid)       cmd = CMD_LOOKUP;
        else if (next_valid)  cmd = CMD_STEP;
        else if (learn_valid) cmd = CMD_LEARN;
        else if (mark_valid)  cmd = CMD_MARK;
        else if (age_tick)    cmd = CMD_AGE;
        else                  cmd = CMD_NONE;
    end

    // One-hot of the slot now reported, used to exclude it on a step.
    always_comb begin
        cur_oh = '0;
        if (rsp_hit_q) begin
            cur_oh[rsp_idx_q] = 1'b1;
        end
    end

    // Slots taking part in this cycle's compare and the key used.
    always_comb begin
        if (cmd == CMD_LOOKUP) begin
            eligible = ~empty_v & ~excl_v;
            cmp_key  = srch_key;
        end else begin
            eligible = ~empty_v & ~excl_v & ~step_v & ~cur_oh;
            cmp_key  = cur_key_q;
        end
    end

    cam_match_array #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_match (
        .keys_flat (keys_flat),
        .key       (cmp_key),
        .eligible  (eligible),
        .match     (match_v)
    );

    cam_prio_enc #(.N(ENTRIES), .IW(IW)) u_hit_enc (
        .req   (match_v),
        .found (m_found),
        .idx   (m_idx)
    );

    cam_prio_enc #(.N(ENTRIES), .IW(IW)) u_free_enc (
        .req   (empty_v),
        .found (f_found),
        .idx   (f_idx)
    );

    // Learning is allowed only after a miss on a loaded key with room left.
    assign do_learn = (cmd == CMD_LEARN) && key_ok_q && !rsp_hit_q && f_found;

    cam_entry_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .IW(IW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_clr   (cmd == CMD_LOOKUP),
        .step_set   ((cmd == CMD_STEP) && rsp_hit_q),
        .step_idx   (rsp_idx_q),
        .touch_en   (((cmd == CMD_LOOKUP) || (cmd == CMD_STEP)) && m_found),
        .touch_idx  (m_idx),
        .learn_en   (do_learn),
        .learn_idx  (f_idx),
        .learn_key  (cur_key_q),
        .mark_en    (cmd == CMD_MARK),
        .mark_idx   (mark_idx),
        .mark_field (mark_field),
        .mark_val   (mark_val),
        .sweep_en   (cmd == CMD_AGE),
        .keys_flat  (keys_flat),
        .free_v     (empty_v),
        .excl_v     (excl_v),
        .step_v     (step_v),
        .pin_v      (perm_v),
        .ref_v      (age_v)
    );

    // Held key and registered result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_key_q   <= '0;
            key_ok_q    <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_idx_q   <= '0;
        end else begin
            rsp_valid_q <= (cmd == CMD_LOOKUP) || (cmd == CMD_STEP);
            if (cmd == CMD_LOOKUP) begin
                cur_key_q <= srch_key;
                key_ok_q  <= 1'b1;
            end
            if ((cmd == CMD_LOOKUP) || (cmd == CMD_STEP)) begin
                rsp_hit_q <= m_found;
                rsp_idx_q <= m_found ? m_idx : '0;
            end else if (do_learn) begin
                rsp_hit_q <= 1'b1;
                rsp_idx_q <= f_idx;
            end
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_hit   = rsp_hit_q;
    assign rsp_idx   = rsp_idx_q;

endmodule

// File: rtl/cam_learn_age_chk.sv
// Checker for cam_learn_age, attached through bind; observes ports and slot flags.
module cam_learn_age_chk #(
    parameter int ENTRIES = 16,
    parameter int IW      = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               srch_valid,
    input logic               next_valid,
    input logic               learn_valid,
    input logic               mark_valid,
    input logic               age_tick,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [IW-1:0]      rsp_idx,
    input logic [ENTRIES-1:0] empty_v,
    input logic [ENTRIES-1:0] perm_v,
    input logic [ENTRIES-1:0] age_v
);

    p_resp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_valid || next_valid) |=> rsp_valid);

    p_resp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(srch_valid || next_valid) |=> !rsp_valid);

    p_hit_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !empty_v[rsp_idx]);

    p_hit_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> age_v[rsp_idx]);

    p_sweep_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_tick && !srch_valid && !next_valid && !learn_valid && !mark_valid)
        |=> (age_v == '0));

    p_pin_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(perm_v & ~empty_v) & empty_v) == '0));

    p_one_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~empty_v) <= $past($countones(~empty_v)) + 1));

endmodule

bind cam_learn_age cam_learn_age_chk #(.ENTRIES(ENTRIES), .IW(IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .srch_valid  (srch_valid),
    .next_valid  (next_valid),
    .learn_valid (learn_valid),
    .mark_valid  (mark_valid),
    .age_tick    (age_tick),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_idx     (rsp_idx),
    .empty_v     (empty_v),
    .perm_v      (perm_v),
    .age_v       (age_v)
);

// File: tb/tb_cam_learn_age.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_cam_learn_age;
    localparam int ENTRIES = 4;
    localparam int KEY_W   = 8;
    localparam int IW      = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             srch_valid = 1'b0;
    logic [KEY_W-1:0] srch_key = '0;
    logic             next_valid = 1'b0;
    logic             learn_valid = 1'b0;
    logic             mark_valid = 1'b0;
    logic [IW-1:0]    mark_idx = '0;
    logic             mark_field = 1'b0;
    logic             mark_val = 1'b0;
    logic             age_tick = 1'b0;
    logic             rsp_valid, rsp_hit;
    logic [IW-1:0]    rsp_idx;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cam_learn_age #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) dut (
        .clk(clk), .rst_n(rst_n), .srch_valid(srch_valid), .srch_key(srch_key),
        .next_valid(next_valid), .learn_valid(learn_valid), .mark_valid(mark_valid),
        .mark_idx(mark_idx), .mark_field(mark_field), .mark_val(mark_val),
        .age_tick(age_tick), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle_all();
        srch_valid = 0; next_valid = 0; learn_valid = 0; mark_valid = 0; age_tick = 0;
    endtask

    // Drive one cycle of commands; results are sampled at the next falling edge.
    task automatic lookup(input logic [KEY_W-1:0] k);
        srch_valid = 1; srch_key = k;
        @(negedge clk);
        idle_all();
    endtask

    task automatic step();
        next_valid = 1;
        @(negedge clk);
        idle_all();
    endtask

    task automatic learn();
        learn_valid = 1;
        @(negedge clk);
        idle_all();
    endtask

    task automatic tick();
        age_tick = 1;
        @(negedge clk);
        idle_all();
    endtask

    task automatic mark(input int idx, input logic field, input logic val);
        mark_valid = 1; mark_idx = IW'(idx); mark_field = field; mark_val = val;
        @(negedge clk);
        idle_all();
    endtask

    task automatic expect_hit(input string req, input logic [KEY_W-1:0] k, input int idx);
        lookup(k);
        check(req, rsp_valid, 1);
        check(req, rsp_hit, 1);
        check(req, rsp_idx, idx);
    endtask

    task automatic expect_miss(input string req, input logic [KEY_W-1:0] k);
        lookup(k);
        check(req, rsp_valid, 1);
        check(req, rsp_hit, 0);
    endtask

    task automatic add_key(input string req, input logic [KEY_W-1:0] k, input int idx);
        expect_miss(req, k);
        learn();
        check(req, rsp_hit, 1);
        check(req, rsp_idx, idx);
        check(req, rsp_valid, 0);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 rsp_valid", rsp_valid, 0);
        check("R1 rsp_hit", rsp_hit, 0);
        expect_miss("R1 empty", 8'h00);
        check("R2 pulse ends", rsp_valid, 1);
        @(negedge clk);
        check("R2 pulse one cycle", rsp_valid, 0);
    endtask

    task automatic t_learn();
        do_reset();
        learn();                       // no key loaded: ignored (R4)
        add_key("R4 first slot", 8'h11, 0);
        expect_hit("R2 hit after learn", 8'h11, 0);
        add_key("R4 second slot", 8'h22, 1);
        learn();                       // after a hit: ignored (R4)
        add_key("R4 learn after hit ignored", 8'h33, 2);
        expect_hit("R2 key kept", 8'h22, 1);
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < ENTRIES; i++) add_key("R4 fill", 8'(i + 1), i);
        expect_miss("R5 miss on full", 8'h55);
        learn();
        expect_miss("R5 learn refused", 8'h55);
        for (int i = 0; i < ENTRIES; i++) expect_hit("R5 keys kept", 8'(i + 1), i);
    endtask

    task automatic t_age();
        do_reset();
        add_key("R6 setup", 8'hA1, 0);
        add_key("R6 setup", 8'hB2, 1);
        add_key("R6 setup", 8'hC3, 2);
        tick();                        // learned slots are referenced: all kept
        mark(2, 1'b0, 1'b1);           // pin slot 2 (R8 field 0)
        lookup(8'hA1);                 // reference slot 0 (R3)
        tick();
        expect_miss("R6 stale released", 8'hB2);
        expect_hit("R3 referenced kept", 8'hA1, 0);
        tick();
        tick();                        // slot 0 unreferenced through a full interval
        expect_miss("R6 two pulses release", 8'hA1);
        expect_hit("R7 pinned kept", 8'hC3, 2);
        add_key("R4 lowest free", 8'hD4, 0);
    endtask

    task automatic t_skip();
        do_reset();
        add_key("R9 setup", 8'h5A, 0);
        mark(0, 1'b1, 1'b1);           // exclude slot 0 (field 1)
        expect_miss("R8 excluded", 8'h5A);
        learn();
        check("R8 duplicate slot", rsp_idx, 1);
        mark(0, 1'b1, 1'b0);
        expect_hit("R8 restored", 8'h5A, 0);
        step();
        check("R9 step valid", rsp_valid, 1);
        check("R9 step second", rsp_hit, 1);
        check("R9 step idx", rsp_idx, 1);
        step();
        check("R9 step end", rsp_hit, 0);
        expect_hit("R9 new key cancels steps", 8'h5A, 0);
        mark(1, 1'b1, 1'b1);
        lookup(8'h5A);
        step();
        check("R9 mark exclusion stays", rsp_hit, 0);
    endtask

    task automatic t_prio();
        do_reset();
        add_key("R10 setup", 8'h10, 0);
        tick();                        // slot 0 now unreferenced
        expect_miss("R10 setup", 8'h20);
        learn_valid = 1; age_tick = 1; // learn wins, sweep dropped
        @(negedge clk);
        idle_all();
        check("R10 learn won", rsp_idx, 1);
        srch_valid = 1; srch_key = 8'h10;
        mark_valid = 1; mark_idx = 0; mark_field = 1'b1; mark_val = 1'b1;
        @(negedge clk);
        idle_all();
        check("R10 sweep dropped", rsp_hit, 1);
        check("R10 lookup won", rsp_idx, 0);
        expect_hit("R10 mark dropped", 8'h10, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_learn();
        t_full();
        t_age();
        t_skip();
        t_prio();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule